// File: doc/BRIEF.md
# Prescaled Run-Controlled Down Timer

This block is a memory-mapped countdown timer with four 32-bit word registers: a control register, a status register, a prescaler register and a timer register. Software loads a prescaler period and an initial timer value while the timer is idle, then writes the start bit. While the timer runs, an internal prescaler counter divides the clock, and the timer value drops by one each time that counter expires. The timer stops by itself when its value reaches zero. Software can also stop it early and read the live count at any time.

Start and stop commands act only when the timer is in the opposite run state. Writes to the prescaler and timer registers are refused while the timer runs, so the configuration cannot change during a count. The block carries no streaming data. Its bus port has no handshake and applies no back-pressure: a write takes effect at the clock edge where `bus_en` and `bus_we` are high, and read data is a combinational function of `bus_addr`.

Top module: `tick_timer`

## Requirements
- R1: After reset all four registers read zero and the timer is stopped.
- R2: `bus_addr` selects a word: 0 is control (write bit 0 = start, bit 1 = stop, reads as zero), 1 is status (bit 0 = running, other bits zero), 2 is prescaler, 3 is timer. Reads return the selected word in the same cycle.
- R3: A start write while stopped, with nonzero prescaler and timer values, sets the running bit from the next cycle on. A start write while running has no effect, and the count continues unchanged.
- R4: Prescaler writes while stopped are stored and read back. Prescaler writes while running are ignored.
- R5: Timer writes while stopped are stored and read back. While running, the timer register reads the live count, and timer writes are ignored.
- R6: With prescaler value P, the timer value decreases by one every P clock cycles. The first decrease lands P cycles after the start write edge.
- R7: When the timer value reaches zero, the running bit clears in the same cycle. A running timer never holds the value zero.
- R8: A start write while the prescaler or the timer value is zero leaves the timer stopped and its value unchanged.
- R9: A stop write while running clears the running bit and holds the current count. A stop write while stopped has no effect. A later start resumes from the held count with a full prescaler period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe; high for one cycle per write |
| bus_we | input | 1 | Write enable, qualified by bus_en |
| bus_addr | input | 2 | Word select (see R2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word selected by bus_addr |

## Verification
The in-design assertions check the following on every cycle:
- a running timer never holds zero;
- the count changes only on a prescaler expiry, and then only by one;
- the run bit clears on the decrement from one and after a stop;
- the prescaler value cannot move while running;
- a zero-valued start is refused;
- the prescaler counter stays below its period.

The exact cycle on which each decrement and the final stop land, relative to the start write, can only be shown by the bench scenarios. The same holds for register readback, refused writes seen through the bus, and resuming from a held count. The bench measures these with a table of prescaler and timer pairs and with directed sequences.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_PRESC = 2'd2,
    SEL_TIMER = 2'd3
  } reg_sel_e;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_HALT_BIT = 1;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             running,
  input  logic [DW-1:0]    timer_val,
  output logic             go_req,
  output logic             halt_req,
  output logic             timer_wr,
  output logic [DW-1:0]    period,
  output logic             period_zero,
  output logic [DW-1:0]    bus_rdata
);
  logic wr;
  logic period_wr;

  assign wr        = bus_en && bus_we;
  assign go_req    = wr && (bus_addr == SEL_CTRL) && bus_wdata[CTRL_GO_BIT];
  assign halt_req  = wr && (bus_addr == SEL_CTRL) && bus_wdata[CTRL_HALT_BIT];
  assign timer_wr  = wr && (bus_addr == SEL_TIMER);
  assign period_wr = wr && (bus_addr == SEL_PRESC);
  assign period_zero = (period == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     period <= '0;
    else if (period_wr && !running) period <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      SEL_STAT:  bus_rdata[0] = running;
      SEL_PRESC: bus_rdata    = period;
      SEL_TIMER: bus_rdata    = timer_val;
      default:   bus_rdata    = '0;
    endcase
  end

  AST_PERIOD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    running && period_wr |=> period == $past(period)); // R4
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [DW-1:0] period,
  output logic          tick
);
  localparam logic [DW-1:0] ONE = 1;
  logic [DW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= period - ONE;
    else if (run) begin
      if (cnt == '0)    cnt <= period - ONE;
      else              cnt <= cnt - ONE;
    end
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load |-> cnt < period); // R6
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_req,
  input  logic          halt_req,
  input  logic          timer_wr,
  input  logic [DW-1:0] wdata,
  input  logic          period_zero,
  input  logic          tick,
  output logic          running,
  output logic [DW-1:0] timer_val,
  output logic          start_go
);
  localparam logic [DW-1:0] ONE = 1;

  assign start_go = go_req && !running && !period_zero && (timer_val != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      timer_val <= '0;
    end else if (start_go) begin
      running <= 1'b1;
    end else if (running) begin
      if (halt_req) running <= 1'b0;
      else if (tick) begin
        timer_val <= timer_val - ONE;
        if (timer_val == ONE) running <= 1'b0;
      end
    end else if (timer_wr) begin
      timer_val <= wdata;
    end
  end

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> timer_val != '0); // R7
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    running && !tick |=> timer_val == $past(timer_val)); // R5
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick && !halt_req |=> timer_val == $past(timer_val) - ONE); // R6
  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    running && tick && !halt_req && timer_val == ONE |=> !running); // R7
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && !running && (period_zero || timer_val == '0) |=> !running && $stable(timer_val)); // R8
  AST_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    running && halt_req |=> !running && $stable(timer_val)); // R9
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [SEL_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata
);
  logic          go_req, halt_req, timer_wr, period_zero;
  logic          running, start_go, tick;
  logic [DW-1:0] period, timer_val;

  tmr_regif #(.DW(DW)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .running(running),
    .timer_val(timer_val), .go_req(go_req), .halt_req(halt_req),
    .timer_wr(timer_wr), .period(period), .period_zero(period_zero),
    .bus_rdata(bus_rdata)
  );

  tmr_prescaler #(.DW(DW)) u_presc (
    .clk(clk), .rst_n(rst_n), .load(start_go), .run(running),
    .period(period), .tick(tick)
  );

  tmr_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .halt_req(halt_req),
    .timer_wr(timer_wr), .wdata(bus_wdata), .period_zero(period_zero),
    .tick(tick), .running(running), .timer_val(timer_val),
    .start_go(start_go)
  );
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // prescaler, timer, expected cycles from start edge to auto stop
  localparam int VEC[6][3] = '{
    '{1, 1, 1}, '{1, 5, 5}, '{3, 4, 12},
    '{7, 2, 14}, '{2, 1, 2}, '{5, 3, 15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], v); chk("R1 reset value", v, 32'd0);
    end

    for (int i = 0; i < 6; i++) begin
      wr(2'd2, VEC[i][0]);
      wr(2'd3, VEC[i][1]);
      peek(2'd2, v); chk("R4 prescaler readback", v, VEC[i][0]);
      peek(2'd3, v); chk("R5 timer readback", v, VEC[i][1]);
      wr(2'd0, 32'h1);
      peek(2'd1, v); chk("R3 running after start", v, 32'd1);
      peek(2'd0, v); chk("R2 control reads zero", v, 32'd0);
      idle(VEC[i][2] - 1);
      peek(2'd3, v); chk("R6 count one cycle before end", v, 32'd1);
      peek(2'd1, v); chk("R6 still running", v, 32'd1);
      idle(1);
      peek(2'd3, v); chk("R7 count at zero", v, 32'd0);
      peek(2'd1, v); chk("R7 stopped at zero", v, 32'd0);
    end

    // R8: zero prescaler
    wr(2'd2, 32'd0); wr(2'd3, 32'd5); wr(2'd0, 32'h1);
    peek(2'd1, v); chk("R8 zero prescaler no start", v, 32'd0);
    idle(3);
    peek(2'd3, v); chk("R8 timer unchanged", v, 32'd5);
    // R8: zero timer
    wr(2'd2, 32'd3); wr(2'd3, 32'd0); wr(2'd0, 32'h1);
    peek(2'd1, v); chk("R8 zero timer no start", v, 32'd0);

    // R3: second start while running does nothing (P=4, T=3 -> 12 cycles)
    wr(2'd2, 32'd4); wr(2'd3, 32'd3); wr(2'd0, 32'h1);
    idle(2);
    wr(2'd0, 32'h1);
    idle(8);
    peek(2'd3, v); chk("R3 restart ignored, count", v, 32'd1);
    idle(1);
    peek(2'd1, v); chk("R3 restart ignored, stop time", v, 32'd0);

    // R4/R5: writes refused while running (P=3, T=5 -> 15 cycles)
    wr(2'd2, 32'd3); wr(2'd3, 32'd5); wr(2'd0, 32'h1);
    wr(2'd2, 32'd9);
    wr(2'd3, 32'd77);
    peek(2'd2, v); chk("R4 prescaler locked", v, 32'd3);
    peek(2'd3, v); chk("R5 timer locked, live", v, 32'd5);
    idle(1);
    peek(2'd3, v); chk("R5 live count", v, 32'd4);
    idle(11);
    peek(2'd3, v); chk("R4 period kept, count", v, 32'd1);
    idle(1);
    peek(2'd1, v); chk("R4 period kept, stop", v, 32'd0);

    // R9: stop, hold, resume (P=2, T=10)
    wr(2'd2, 32'd2); wr(2'd3, 32'd10); wr(2'd0, 32'h1);
    idle(4);
    wr(2'd0, 32'h2);
    peek(2'd1, v); chk("R9 stop clears run", v, 32'd0);
    peek(2'd3, v); chk("R9 count held", v, 32'd8);
    idle(3);
    wr(2'd0, 32'h2);
    peek(2'd3, v); chk("R9 stop while stopped", v, 32'd8);
    peek(2'd1, v); chk("R9 stays stopped", v, 32'd0);
    wr(2'd0, 32'h1);
    idle(15);
    peek(2'd3, v); chk("R9 resumed count", v, 32'd1);
    idle(1);
    peek(2'd1, v); chk("R9 resumed stop", v, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule